// File: doc/BRIEF.md
# Circular Pre/Post-Trigger Sample Capture

This block records logic samples into an on-chip memory that it treats as a circular buffer. Once armed, it writes every valid sample and wraps at the end of the buffer, so the oldest data is always the next to be overwritten. The trigger input is looked at only while the block is waiting for its first trigger. The slot of the trigger sample is recorded, and a programmed number of further samples is stored before writing stops. After that, a request-driven read port returns the stored samples in time order, oldest first. The block then goes back to idle.

Two storage widths are offered. Full width keeps all 16 channels, one sample per memory word. Narrow width keeps only 8 channels, either the lower byte or the upper byte of the sample, and packs two such samples into each 16-bit word, so the buffer holds twice as many samples. The depth is a parameter. A 40 KB buffer corresponds to a DEPTH of 20480 words. The default is smaller, so the block stays cheap to elaborate.

Top module: `ring_capture`

## Requirements
- R1: After reset, armed_o, done_o, wrapped_o and rd_valid_o are all 0.
- R2: A high arm_i while idle starts a capture. armed_o is 1 after that edge. The write slot restarts at 0, and narrow_i, upper_i and post_cnt_i are latched at that edge.
- R3: While armed, every cycle with smp_valid_i high stores the sample in the next slot. Slots run from 0 up to capacity minus 1 and then wrap to 0, overwriting old data. The capacity is DEPTH in full width and 2*DEPTH in narrow width. wrapped_o goes to 1 at the first wrap and stays at 1 until the next capture starts.
- R4: The trigger is taken only while waiting for the first trigger, and only in a cycle where smp_valid_i is also high. That sample is the trigger sample, and trig_ptr_o gives its slot. A trigger while idle, a trigger in a cycle without a valid sample, and any later trigger are all ignored.
- R5: After the trigger sample, exactly N more valid samples are stored, where N is the latched post count. done_o rises at the edge that stores the last of them. When N is 0, done_o rises at the edge that stores the trigger sample. armed_o falls at the same edge.
- R6: A post count larger than capacity minus 1 is clamped to capacity minus 1, so the trigger sample is never overwritten.
- R7: Readout works only while done_o is 1. Each rd_en_i request gives one sample, with rd_valid_o high in the next cycle. If the buffer wrapped, readout starts at the stop slot and returns capacity samples. If it did not wrap, readout starts at slot 0 and returns one sample per slot written. rd_last_o marks the final sample. The final request returns the block to idle, and rd_en_i has no effect at any other time.
- R8: In full width, rd_data_o returns the whole 16-bit sample. In narrow width, the stored byte is smp_i[7:0] when upper_i is 0 and smp_i[15:8] when upper_i is 1. It is returned on rd_data_o[7:0] with rd_data_o[15:8] equal to 0.
- R9: arm_i is ignored while a capture is armed or complete. In that case the write slot, the width and the post count are all left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a capture (idle only) |
| narrow_i | input | 1 | 1: store 8 channels, 0: store all 16 |
| upper_i | input | 1 | Narrow width: 1 keeps the upper byte, 0 the lower byte |
| post_cnt_i | input | CNT_W | Samples to store after the trigger sample |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 2*LANE_W | Sample channels |
| trig_i | input | 1 | Trigger condition |
| rd_en_i | input | 1 | Readout request |
| armed_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture stopped, readout allowed |
| wrapped_o | output | 1 | Buffer has wrapped at least once |
| trig_ptr_o | output | PTR_W | Slot of the trigger sample |
| rd_valid_o | output | 1 | Readout sample valid |
| rd_data_o | output | 2*LANE_W | Readout sample |
| rd_last_o | output | 1 | Final readout sample |

## Verification
The bench builds the block with DEPTH = 8 and LANE_W = 8. That gives a capacity of 8 samples in full width and 16 in narrow width. It also makes the post-count field 5 bits wide, so it can carry values up to 31. At this depth a few dozen samples are enough to wrap the buffer in both widths. A post count of 31 can then be clamped, and a readout that starts in the middle of the buffer can be checked against a model of the slots. An arm pulse in the middle of a capture, a second trigger, and trigger pulses on cycles without a valid sample all fit within one short capture.

// File: rtl/ring_capture_pkg.sv
`timescale 1ns/1ps
package ring_capture_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/ring_capture_ctrl.sv
`timescale 1ns/1ps
module ring_capture_ctrl
  import ring_capture_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             narrow_i,
  input  logic             upper_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             smp_valid_i,
  input  logic             trig_i,
  input  logic             rd_fin_i,
  output cap_state_e       state_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             narrow_o,
  output logic             upper_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [PTR_W-1:0] trig_ptr_o,
  output logic             wrapped_o,
  output logic [PTR_W-1:0] rd_start_o,
  output logic [CNT_W-1:0] rd_count_o
);
  cap_state_e       st_q;
  logic [PTR_W-1:0] wr_ptr_q, trig_ptr_q;
  logic [CNT_W-1:0] cap_q, post_q, rem_q;
  logic [CNT_W-1:0] cap_arm, post_clamp;
  logic             wrapped_q, narrow_q, upper_q, wr_en, wr_last;

  assign cap_arm    = narrow_i ? CNT_W'(2 * DEPTH) : CNT_W'(DEPTH);
  // keep the trigger sample inside the buffer
  assign post_clamp = (post_cnt_i > cap_arm - 1'b1) ? cap_arm - 1'b1 : post_cnt_i;
  assign wr_en      = smp_valid_i && (st_q == ST_ARMED || st_q == ST_POST);
  assign wr_last    = (CNT_W'(wr_ptr_q) == cap_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wr_ptr_q   <= '0;
      trig_ptr_q <= '0;
      wrapped_q  <= 1'b0;
      narrow_q   <= 1'b0;
      upper_q    <= 1'b0;
      cap_q      <= CNT_W'(DEPTH);
      post_q     <= '0;
      rem_q      <= '0;
    end else begin
      if (st_q == ST_IDLE && arm_i) begin
        wr_ptr_q  <= '0;
        wrapped_q <= 1'b0;
        narrow_q  <= narrow_i;
        upper_q   <= upper_i;
        cap_q     <= cap_arm;
        post_q    <= post_clamp;
      end else if (wr_en) begin
        wr_ptr_q <= wr_last ? '0 : wr_ptr_q + 1'b1;
        if (wr_last) wrapped_q <= 1'b1;
      end
      case (st_q)
        ST_IDLE:  if (arm_i) st_q <= ST_ARMED;
        ST_ARMED: if (wr_en && trig_i) begin
          trig_ptr_q <= wr_ptr_q;
          rem_q      <= post_q;
          st_q       <= (post_q == '0) ? ST_DONE : ST_POST;
        end
        ST_POST:  if (wr_en) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) st_q <= ST_DONE;
        end
        default:  if (rd_fin_i) st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = st_q;
  assign wr_en_o    = wr_en;
  assign wr_ptr_o   = wr_ptr_q;
  assign narrow_o   = narrow_q;
  assign upper_o    = upper_q;
  assign cap_o      = cap_q;
  assign trig_ptr_o = trig_ptr_q;
  assign wrapped_o  = wrapped_q;
  assign rd_start_o = wrapped_q ? wr_ptr_q : '0;
  assign rd_count_o = wrapped_q ? cap_q : CNT_W'(wr_ptr_q);
endmodule

// File: rtl/ring_capture_rd.sv
`timescale 1ns/1ps
module ring_capture_rd #(
  parameter int PTR_W = 11,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             rd_en_i,
  output logic             re_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             last_o
);
  logic [CNT_W-1:0] ofs_q, sum, wrapd;

  assign sum    = CNT_W'(start_i) + ofs_q;
  assign wrapd  = (sum >= cap_i) ? sum - cap_i : sum;
  assign ptr_o  = wrapd[PTR_W-1:0];
  assign re_o   = en_i && rd_en_i && (ofs_q < count_i);
  assign last_o = re_o && (ofs_q == count_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ofs_q <= '0;
    else if (!en_i) ofs_q <= '0;
    else if (re_o)  ofs_q <= ofs_q + 1'b1;
  end
endmodule

// File: rtl/ring_capture_mem.sv
`timescale 1ns/1ps
module ring_capture_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ring_capture.sv
`timescale 1ns/1ps
module ring_capture
  import ring_capture_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int CNT_W  = PTR_W + 1,
  localparam int SMP_W  = 2 * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             narrow_i,
  input  logic             upper_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             trig_i,
  input  logic             rd_en_i,
  output logic             armed_o,
  output logic             done_o,
  output logic             wrapped_o,
  output logic [PTR_W-1:0] trig_ptr_o,
  output logic             rd_valid_o,
  output logic [SMP_W-1:0] rd_data_o,
  output logic             rd_last_o
);
  cap_state_e        state;
  logic              wr_en, narrow_q, upper_q, re, rd_last;
  logic [PTR_W-1:0]  wr_ptr, rd_start, rd_ptr;
  logic [CNT_W-1:0]  cap, rd_count;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [LANE_W-1:0] narrow_byte;
  logic [LANE_W-1:0] lane_rdata [2];
  logic              rd_valid_q, rd_last_q, rd_narrow_q, rd_lane_q;

  ring_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .narrow_i, .upper_i, .post_cnt_i,
    .smp_valid_i, .trig_i,
    .rd_fin_i   (rd_last),
    .state_o    (state),
    .wr_en_o    (wr_en),
    .wr_ptr_o   (wr_ptr),
    .narrow_o   (narrow_q),
    .upper_o    (upper_q),
    .cap_o      (cap),
    .trig_ptr_o (trig_ptr_o),
    .wrapped_o  (wrapped_o),
    .rd_start_o (rd_start),
    .rd_count_o (rd_count)
  );

  ring_capture_rd #(.PTR_W(PTR_W)) u_rd (
    .clk_i, .rst_ni,
    .en_i    (state == ST_DONE),
    .start_i (rd_start),
    .count_i (rd_count),
    .cap_i   (cap),
    .rd_en_i,
    .re_o    (re),
    .ptr_o   (rd_ptr),
    .last_o  (rd_last)
  );

  // narrow width: slot bit 0 picks the byte lane of the word
  assign waddr       = narrow_q ? wr_ptr[PTR_W-1:1] : wr_ptr[ADDR_W-1:0];
  assign raddr       = narrow_q ? rd_ptr[PTR_W-1:1] : rd_ptr[ADDR_W-1:0];
  assign narrow_byte = upper_q ? smp_i[SMP_W-1:LANE_W] : smp_i[LANE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic              lane_we;
    logic [LANE_W-1:0] lane_wdata;
    assign lane_we    = wr_en && (!narrow_q || wr_ptr[0] == 1'(g));
    assign lane_wdata = narrow_q ? narrow_byte : smp_i[g*LANE_W +: LANE_W];
    ring_capture_mem #(.DEPTH(DEPTH), .DW(LANE_W)) u_mem (
      .clk_i,
      .we_i    (lane_we),
      .waddr_i (waddr),
      .wdata_i (lane_wdata),
      .re_i    (re),
      .raddr_i (raddr),
      .rdata_o (lane_rdata[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q  <= 1'b0;
      rd_last_q   <= 1'b0;
      rd_narrow_q <= 1'b0;
      rd_lane_q   <= 1'b0;
    end else begin
      rd_valid_q <= re;
      rd_last_q  <= rd_last;
      if (re) begin
        rd_narrow_q <= narrow_q;
        rd_lane_q   <= rd_ptr[0];
      end
    end
  end

  assign armed_o    = (state == ST_ARMED) || (state == ST_POST);
  assign done_o     = (state == ST_DONE);
  assign rd_valid_o = rd_valid_q;
  assign rd_last_o  = rd_last_q;
  assign rd_data_o  = rd_narrow_q ? {LANE_W'(0), rd_lane_q ? lane_rdata[1] : lane_rdata[0]}
                                  : {lane_rdata[1], lane_rdata[0]};
endmodule

// File: rtl/ring_capture_chk.sv
`timescale 1ns/1ps
module ring_capture_chk #(
  parameter int PTR_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             rd_en_i,
  input logic             armed_o,
  input logic             done_o,
  input logic             wrapped_o,
  input logic [PTR_W-1:0] trig_ptr_o,
  input logic             rd_valid_o,
  input logic             rd_last_o
);
  p_wrap_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrapped_o && armed_o) |=> wrapped_o);

  p_trig_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |=> $stable(trig_ptr_o));

  p_done_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(smp_valid_i) && $past(armed_o));

  p_valid_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i) && $past(done_o));

  p_no_read_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> !rd_valid_o);

  p_last_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  p_state_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({armed_o, done_o}));
endmodule

bind ring_capture ring_capture_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/ring_capture_tb.sv
`timescale 1ns/1ps
module ring_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int LANE_W = 8;
  localparam int PTR_W  = 4;
  localparam int CNT_W  = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arm_i = 0, narrow_i = 0, upper_i = 0, smp_valid_i = 0, trig_i = 0, rd_en_i = 0;
  logic [CNT_W-1:0] post_cnt_i = '0;
  logic [15:0] smp_i = '0;
  logic armed_o, done_o, wrapped_o, rd_valid_o, rd_last_o;
  logic [PTR_W-1:0] trig_ptr_o;
  logic [15:0] rd_data_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ring_capture #(.DEPTH(DEPTH), .LANE_W(LANE_W)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  bit          lst_q [$];
  logic [15:0] mdl [16];
  int wp, cap, seq = 1;
  bit wrp, nar, upp;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: scoreboard pop on every readout sample
  initial forever begin
    @(posedge clk_i); #1;
    if (rd_valid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected readout: actual %0h expected none", rd_data_o);
      end else begin
        logic [15:0] e; bit l;
        e = exp_q.pop_front(); l = lst_q.pop_front();
        if (rd_data_o !== e || rd_last_o !== l) begin
          n_bad++;
          $display("FAIL R7/R8 readout: actual %0h/%0b expected %0h/%0b", rd_data_o, rd_last_o, e, l);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  task automatic do_arm(bit n, bit u, int post);
    arm_i = 1; narrow_i = n; upper_i = u; post_cnt_i = CNT_W'(post);
    tick();
    arm_i = 0;
    nar = n; upp = u; cap = n ? 2*DEPTH : DEPTH; wp = 0; wrp = 0;
    chk("R2 armed after arm", armed_o, 1);
  endtask

  // one valid sample; optional trigger and stray arm; gap cycles drive trig without valid
  task automatic put(bit trig, bit arm_x, int gap);
    logic [15:0] s;
    s = {seq[7:0] ^ 8'hC3, seq[7:0]}; seq++;
    smp_i = s; smp_valid_i = 1; trig_i = trig;
    arm_i = arm_x; narrow_i = ~nar; post_cnt_i = '0;
    tick();
    smp_valid_i = 0; trig_i = 0; arm_i = 0;
    mdl[wp] = nar ? {8'h00, upp ? s[15:8] : s[7:0]} : s;
    if (wp == cap - 1) begin wp = 0; wrp = 1; end else wp++;
    for (int i = 0; i < gap; i++) begin
      trig_i = 1; tick(); trig_i = 0;
    end
  endtask

  task automatic capture(bit n, bit u, int post, int npre, int gap, bit stray);
    int rem, tslot, start, cnt;
    do_arm(n, u, post);
    for (int i = 0; i < npre; i++) begin
      put(0, stray && i == 1, gap);
      chk("R3 no stop before trigger", done_o, 0);
      chk("R9 still armed", armed_o, 1);
    end
    tslot = wp;
    put(1, 0, 0);
    rem = (post > cap - 1) ? cap - 1 : post;
    chk("R4 trigger slot", trig_ptr_o, tslot);
    chk("R5/R6 done after trigger", done_o, rem == 0);
    while (rem > 0) begin
      put(stray && rem == 2, 0, gap);
      rem--;
      chk("R5/R6 done count", done_o, rem == 0);
      chk("R5 armed drops at done", armed_o, rem != 0);
      chk("R4 second trigger ignored", trig_ptr_o, tslot);
    end
    chk("R3 wrapped flag", wrapped_o, wrp);
    start = wrp ? wp : 0;
    cnt   = wrp ? cap : wp;
    for (int k = 0; k < cnt; k++) begin
      exp_q.push_back(mdl[(start + k) % cap]);
      lst_q.push_back(k == cnt - 1);
    end
    rd_en_i = 1;
    for (int k = 0; k < cnt + 2; k++) begin
      tick();
      if (k == 1) rd_en_i = 0;
      if (k == 2) rd_en_i = 1;
    end
    rd_en_i = 0;
    tick(); tick();
    chk("R7 idle after readout", done_o, 0);
    chk("R7 all samples read", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 armed reset", armed_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 wrapped reset", wrapped_o, 0);
    chk("R1 rd_valid reset", rd_valid_o, 0);
    rst_ni = 1;
    tick();
    // idle: trigger with sample and readout request are ignored
    smp_valid_i = 1; trig_i = 1; rd_en_i = 1; smp_i = 16'hDEAD;
    tick(); tick();
    smp_valid_i = 0; trig_i = 0; rd_en_i = 0;
    tick();
    chk("R4 idle trigger ignored", done_o, 0);
    chk("R4 idle stays idle", armed_o, 0);

    capture(0, 0, 2, 3, 0, 0);   // full width, no wrap
    capture(0, 0, 3, 11, 0, 0);  // full width, wrapped
    capture(1, 0, 0, 20, 0, 0);  // narrow lower, post 0
    capture(1, 1, 31, 2, 0, 0);  // narrow upper, clamped post
    capture(0, 0, 20, 4, 1, 1);  // stray arm, trig without valid, second trigger

    repeat (3) tick();
    summary();
    $finish;
  end
endmodule